// File: doc/BRIEF.md
# DMA Completion Interrupt Banks

This block collects completion events from up to sixteen DMA channels and turns them into one level-sensitive interrupt line. Every channel can report three kinds of event: half of the current descriptor's data has moved, the current descriptor has finished, and the whole descriptor chain has finished. Each event arrives as a one-cycle pulse and latches a pending bit that stays set until software clears it.

Software sees two kinds of 32-bit register over a simple memory-mapped bus: enable banks and pending banks. A bank covers eight channels, one 4-bit lane per channel. Enable banks are plain read/write storage, so a driver can rework one channel's lane by read-modify-write without disturbing the others. Pending banks are cleared by writing ones. The interrupt line is high whenever any pending bit has its matching enable bit set.

There is no sequencing state machine. The block is a set of per-channel lane cells, an address decoder and a registered read port. Its only state is the enable and pending flops and the read data register.

Top module: `irq_bank_ctrl`

## Requirements
- R1: After reset every enable bit and every pending bit is zero, `irq` is low and `bus_rdata` reads zero.
- R2: Channel n occupies bank n/8 at bit offset (n mod 8)*4. Within a lane, bit 0 is the half-transfer event, bit 1 is descriptor done and bit 2 is chain done. Enable bank k is at byte address 0x00+4k and pending bank k is at 0x10+4k.
- R3: An event pulse sets its pending bit whether or not the matching enable bit is set. A pending bit whose enable is clear does not raise `irq`.
- R4: A write to a pending bank clears exactly the bits written as one. Bits written as zero keep their value.
- R5: If an event pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R6: A write to an enable bank replaces that bank's enable bits, and reading it back returns them. A read-modify-write of one lane leaves the other lanes unchanged.
- R7: Bit 3 of every lane reads as zero in both bank kinds, and writes to it are ignored.
- R8: `irq` goes high in the cycle after the clock edge that latches an enabled event. It goes low after the edge that clears the last enabled pending bit.
- R9: Writing zero to every enable bank drives `irq` low even while pending bits remain set.
- R10: Read data appears one clock after `bus_rd` and holds until the next read. Unmapped or misaligned addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| evt_half | input | NUM_CH | Half-transfer event pulse, one bit per channel |
| evt_desc | input | NUM_CH | Descriptor-done event pulse, one bit per channel |
| evt_chain | input | NUM_CH | Chain-done event pulse, one bit per channel |
| irq | output | 1 | Interrupt request, level |

## Verification
Two functions can fall in the same cycle: a channel's event pulse, and a write-one-to-clear to the pending bank that holds the same bit. The bench provokes this by driving the event and the clearing write on the same falling edge, so that one rising edge sees both. It then reads the bank back. The colliding bit must still be set, while a bit cleared by the same write with no event against it must be gone. A second case clears one bit while a different channel's event lands in the same bank, to show that the clear does not mask the new event.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    // geometry of one channel lane and one bank
    localparam int LANE_W      = 4;
    localparam int KIND_W      = 3;
    localparam int CH_PER_BANK = 8;

    // bit position of each event kind inside a lane
    localparam int BIT_HALF  = 0;
    localparam int BIT_DESC  = 1;
    localparam int BIT_CHAIN = 2;

    // byte address bases of the two register kinds
    localparam int ENABLE_BASE = 'h00;
    localparam int STATUS_BASE = 'h10;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_STATUS = 2'd2
    } reg_kind_e;

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
    import irq_bank_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_BANK = 2,
    localparam int BANK_W  = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [BANK_W-1:0] bank
);

    always_comb begin
        kind = SEL_NONE;
        bank = '0;
        for (int b = 0; b < NUM_BANK; b++) begin
            if (addr == ADDR_W'(ENABLE_BASE + 4 * b)) begin
                kind = SEL_ENABLE;
                bank = BANK_W'(b);
            end
            if (addr == ADDR_W'(STATUS_BASE + 4 * b)) begin
                kind = SEL_STATUS;
                bank = BANK_W'(b);
            end
        end
    end

endmodule

// File: rtl/irq_lane_cell.sv
module irq_lane_cell
    import irq_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic              st_clr,
    input  logic [KIND_W-1:0] lane_wdata,
    input  logic [KIND_W-1:0] evt,
    output logic [KIND_W-1:0] en_q,
    output logic [KIND_W-1:0] st_q,
    output logic              hit
);

    logic [KIND_W-1:0] clr_bits;

    assign clr_bits = st_clr ? lane_wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            if (en_wr) begin
                en_q <= lane_wdata;
            end
            // a new event takes priority over a clear of the same bit
            st_q <= (st_q & ~clr_bits) | evt;
        end
    end

    assign hit = |(st_q & en_q);

endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irq_bank_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_CH-1:0] evt_half,
    input  logic [NUM_CH-1:0] evt_desc,
    input  logic [NUM_CH-1:0] evt_chain,
    output logic              irq
);

    localparam int NUM_BANK = (NUM_CH + CH_PER_BANK - 1) / CH_PER_BANK;
    localparam int BANK_W   = (NUM_BANK > 1) ? $clog2(NUM_BANK) : 1;
    localparam int FLAT_W   = NUM_CH * KIND_W;

    reg_kind_e           acc_kind;
    logic [BANK_W-1:0]   acc_bank;
    logic [FLAT_W-1:0]   en_flat;
    logic [FLAT_W-1:0]   st_flat;
    logic [NUM_CH-1:0]   hit_vec;
    logic [DATA_W-1:0]   en_bank [NUM_BANK];
    logic [DATA_W-1:0]   st_bank [NUM_BANK];

    irq_bank_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_BANK (NUM_BANK)
    ) u_decode (
        .addr (bus_addr),
        .kind (acc_kind),
        .bank (acc_bank)
    );

    // one lane cell per channel
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
        localparam int B   = ch / CH_PER_BANK;
        localparam int OFF = (ch % CH_PER_BANK) * LANE_W;

        logic              en_wr;
        logic              st_clr;
        logic [KIND_W-1:0] evt;

        assign en_wr  = bus_wr && (acc_kind == SEL_ENABLE) && (acc_bank == BANK_W'(B));
        assign st_clr = bus_wr && (acc_kind == SEL_STATUS) && (acc_bank == BANK_W'(B));

        always_comb begin
            evt            = '0;
            evt[BIT_HALF]  = evt_half[ch];
            evt[BIT_DESC]  = evt_desc[ch];
            evt[BIT_CHAIN] = evt_chain[ch];
        end

        irq_lane_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_wr      (en_wr),
            .st_clr     (st_clr),
            .lane_wdata (bus_wdata[OFF +: KIND_W]),
            .evt        (evt),
            .en_q       (en_flat[ch*KIND_W +: KIND_W]),
            .st_q       (st_flat[ch*KIND_W +: KIND_W]),
            .hit        (hit_vec[ch])
        );
    end

    // pack lanes into bus-visible banks, spare lane bit reads zero
    always_comb begin
        for (int b = 0; b < NUM_BANK; b++) begin
            en_bank[b] = '0;
            st_bank[b] = '0;
            for (int s = 0; s < CH_PER_BANK; s++) begin
                if (b * CH_PER_BANK + s < NUM_CH) begin
                    en_bank[b][s*LANE_W +: KIND_W] = en_flat[(b*CH_PER_BANK+s)*KIND_W +: KIND_W];
                    st_bank[b][s*LANE_W +: KIND_W] = st_flat[(b*CH_PER_BANK+s)*KIND_W +: KIND_W];
                end
            end
        end
    end

    // registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            unique case (acc_kind)
                SEL_ENABLE: bus_rdata <= en_bank[acc_bank];
                SEL_STATUS: bus_rdata <= st_bank[acc_bank];
                default:    bus_rdata <= '0;
            endcase
        end
    end

    assign irq = |hit_vec;

    // write data bits that no lane stores (spare lane bits, unused upper lanes)
    logic wdata_spare_sink;
    always_comb begin
        wdata_spare_sink = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if ((i % LANE_W) >= KIND_W || (i / LANE_W) >= NUM_CH) begin
                wdata_spare_sink = wdata_spare_sink ^ bus_wdata[i];
            end
        end
    end

endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk
    import irq_bank_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int FLAT_W = NUM_CH * KIND_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] evt_half,
    input logic [NUM_CH-1:0] evt_desc,
    input logic [NUM_CH-1:0] evt_chain,
    input logic              irq,
    input logic [FLAT_W-1:0] en_flat,
    input logic [FLAT_W-1:0] st_flat
);

    function automatic logic [DATA_W-1:0] spare_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if ((i % LANE_W) >= KIND_W) m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] SPARE = spare_mask();

    logic [FLAT_W-1:0] evt_flat;
    logic [FLAT_W-1:0] clr_mask;

    // independent model of lane placement for status clears
    always_comb begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
            evt_flat[ch*KIND_W + BIT_HALF]  = evt_half[ch];
            evt_flat[ch*KIND_W + BIT_DESC]  = evt_desc[ch];
            evt_flat[ch*KIND_W + BIT_CHAIN] = evt_chain[ch];
            for (int k = 0; k < KIND_W; k++) begin
                clr_mask[ch*KIND_W + k] = bus_wr
                    && (bus_addr == ADDR_W'(STATUS_BASE + 4 * (ch / CH_PER_BANK)))
                    && bus_wdata[(ch % CH_PER_BANK) * LANE_W + k];
            end
        end
    end

    assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_flat) |=> ((st_flat & $past(evt_flat)) == $past(evt_flat)));

    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_mask) |=> ((st_flat & $past(clr_mask & ~evt_flat)) == '0));

    assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_mask & evt_flat)) |=>
            ((st_flat & $past(clr_mask & evt_flat)) == $past(clr_mask & evt_flat)));

    assert_spare_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rdata & SPARE) == '0));

    assert_irq_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !(|evt_flat)) |=> $stable(irq));

    assert_silenced_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_flat == '0) |-> !irq);

endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_half  (evt_half),
    .evt_desc  (evt_desc),
    .evt_chain (evt_chain),
    .irq       (irq),
    .en_flat   (en_flat),
    .st_flat   (st_flat)
);

// File: tb/irq_bank_ctrl_bench.sv
module irq_bank_ctrl_bench;

    localparam int NCH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] evt_half = '0;
    logic [NCH-1:0] evt_desc = '0;
    logic [NCH-1:0] evt_chain = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_bank_ctrl #(.NUM_CH(NCH), .ADDR_W(8), .DATA_W(32)) u_irq_bank_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_half  (evt_half),
        .evt_desc  (evt_desc),
        .evt_chain (evt_chain),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // kind: 0 half, 1 descriptor done, 2 chain done
    task automatic pulse(input int ch, input int kind);
        @(negedge clk);
        if (kind == 0) evt_half[ch] = 1'b1;
        if (kind == 1) evt_desc[ch] = 1'b1;
        if (kind == 2) evt_chain[ch] = 1'b1;
        @(negedge clk);
        evt_half = '0; evt_desc = '0; evt_chain = '0;
    endtask

    task automatic clear_all();
        bus_write(8'h00, 32'h0);
        bus_write(8'h04, 32'h0);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h14, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq after reset", {31'b0, irq}, 32'h0);
        check("R1 rdata after reset", bus_rdata, 32'h0);
        bus_read(8'h00, v); check("R1 enable0", v, 32'h0);
        bus_read(8'h04, v); check("R1 enable1", v, 32'h0);
        bus_read(8'h10, v); check("R1 status0", v, 32'h0);
        bus_read(8'h14, v); check("R1 status1", v, 32'h0);
    endtask

    task automatic t_layout();
        logic [31:0] v;
        pulse(0, 0);
        bus_read(8'h10, v); check("R2 ch0 half in status0", v, 32'h0000_0001);
        check("R3 unenabled event keeps irq low", {31'b0, irq}, 32'h0);
        pulse(5, 1);
        bus_read(8'h10, v); check("R2 ch5 desc bit21", v, 32'h0020_0001);
        pulse(13, 2);
        pulse(15, 0);
        bus_read(8'h14, v); check("R2 ch13 chain bit22 ch15 half bit28", v, 32'h1040_0000);
        check("R3 irq still low", {31'b0, irq}, 32'h0);
        clear_all();
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        pulse(1, 0);
        pulse(2, 1);
        bus_read(8'h10, v); check("R4 two pending", v, 32'h0000_0210);
        bus_write(8'h10, 32'h0000_0010);
        bus_read(8'h10, v); check("R4 only written one cleared", v, 32'h0000_0200);
        bus_write(8'h10, 32'h0);
        bus_read(8'h10, v); check("R4 zero write keeps bits", v, 32'h0000_0200);
        bus_write(8'h10, 32'h0000_0200);
        bus_read(8'h10, v); check("R4 last bit cleared", v, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        pulse(3, 0);
        bus_read(8'h10, v); check("R5 setup bit12", v, 32'h0000_1000);
        // clear and event on the same bit in the same cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h0000_1000; evt_half[3] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; evt_half = '0;
        bus_read(8'h10, v); check("R5 event beats clear", v, 32'h0000_1000);
        // clear one bit while another channel of the bank fires
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h0000_1000; evt_desc[4] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; evt_desc = '0;
        bus_read(8'h10, v); check("R5 clear plus other event", v, 32'h0002_0000);
        clear_all();
    endtask

    task automatic t_enable_rw();
        logic [31:0] v;
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h00, v); check("R7 spare bits read zero", v, 32'h7777_7777);
        bus_write(8'h04, 32'h1234_5670);
        bus_read(8'h04, v); check("R6 enable1 readback", v, 32'h1234_5670);
        // rework ch9 lane only
        v = (v & ~32'h0000_00F0) | 32'h0000_0020;
        bus_write(8'h04, v);
        bus_read(8'h04, v); check("R6 read-modify-write one lane", v, 32'h1234_5620);
        bus_read(8'h00, v); check("R6 other bank untouched", v, 32'h7777_7777);
        clear_all();
    endtask

    task automatic t_irq();
        logic [31:0] v;
        bus_write(8'h00, 32'h0200_0000);   // ch6 descriptor done
        pulse(6, 0);
        check("R8 non-enabled kind no irq", {31'b0, irq}, 32'h0);
        pulse(6, 1);
        check("R8 irq rises after enabled event", {31'b0, irq}, 32'h1);
        bus_write(8'h10, 32'h0200_0000);
        check("R8 irq falls after clear", {31'b0, irq}, 32'h0);
        bus_read(8'h10, v); check("R8 half bit still pending", v, 32'h0100_0000);
        clear_all();
    endtask

    task automatic t_silence();
        logic [31:0] v;
        bus_write(8'h00, 32'h7777_7777);
        bus_write(8'h04, 32'h0000_0400);
        pulse(10, 2);
        pulse(0, 1);
        check("R9 irq high before silence", {31'b0, irq}, 32'h1);
        bus_write(8'h00, 32'h0);
        check("R9 one bank still enabled", {31'b0, irq}, 32'h1);
        bus_write(8'h04, 32'h0);
        check("R9 irq silenced", {31'b0, irq}, 32'h0);
        bus_read(8'h14, v); check("R9 status kept", v, 32'h0000_0400);
        clear_all();
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        bus_write(8'h00, 32'h0000_0007);
        pulse(7, 2);
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_write(8'h11, 32'hFFFF_FFFF);
        bus_read(8'h00, v); check("R10 enable unchanged by stray writes", v, 32'h0000_0007);
        bus_read(8'h10, v); check("R10 status unchanged by stray writes", v, 32'h4000_0000);
        bus_read(8'h08, v); check("R10 unmapped reads zero", v, 32'h0);
        bus_read(8'h10, v);
        repeat (3) @(negedge clk);
        check("R10 rdata holds between reads", bus_rdata, 32'h4000_0000);
        bus_read(8'h12, v); check("R10 misaligned reads zero", v, 32'h0);
        clear_all();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_w1c();
        t_set_wins();
        t_enable_rw();
        t_irq();
        t_silence();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule